// File: doc/BRIEF.md
# Bus Interface Mode Configuration Register

This block is one host-visible configuration word of a bus-mastering peripheral. It holds four live fields: an arbitration priority bit, a 32-bit I/O mode flag, a read-burst enable and a write-burst enable. A fifth position always reads as one. The host writes the word through a simple configuration write strobe with 16 bits of data. The current value is always visible on a read-data output. The individual fields are also brought out as separate flags, which the rest of the device uses.

The block also watches every host I/O write, with its offset from the I/O base and a flag that marks a 32-bit-wide access. The host cannot write the I/O mode flag directly. The flag is set only by a 32-bit write to the data-port offset (0x10), and only a hard reset clears it again.

An external burst-permit input, while low, holds the read-burst enable at zero and blocks host writes to it. Hard reset is asynchronous and active low. Soft reset is a separate input and has no effect on this word.

Top module: `bus_mode_cfg_reg`

## Requirements
- R1: After hard reset (`hardRstN` low) the read data is 0x0100 and all four flag outputs are 0.
- R2: Bit 8 of the read data always reads 1, whatever value is written to it.
- R3: With `burstPermit` high, a configuration write loads bit 9 (priority), bit 6 (read-burst enable) and bit 5 (write-burst enable) from the write data. The new value is visible after the next rising clock edge.
- R4: Writing bit 7 through the configuration port never changes the I/O mode flag.
- R5: An I/O write with `ioDword`=1 and `ioOffset`=0x10 sets bit 7 (`dwordMode`) at the next rising edge.
- R6: An I/O write with `ioDword`=0 to offset 0x10, or any I/O write to another offset, leaves bit 7 unchanged.
- R7: Once bit 7 is 1, it stays 1 through configuration writes and soft reset. Only a hard reset clears it.
- R8: Asserting `softRst` changes no bit of the word.
- R9: While `burstPermit` is low, a configuration write leaves bit 6 at 0. Bits 9 and 5 are still loaded.
- R10: If `burstPermit` goes low while bit 6 is 1, bit 6 clears at the next rising edge. Bit 5 is unaffected.
- R11: Read-data bits 15:10 and 4:0 always read 0.
- R12: `prioHigh`, `dwordMode`, `rdBurstEn` and `wrBurstEn` equal read-data bits 9, 7, 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous hard reset, active low |
| softRst | input | 1 | Soft reset; has no effect on this word |
| cfgWrEn | input | 1 | Host write strobe for this configuration word |
| cfgWrData | input | 16 | Host write data |
| ioWrEn | input | 1 | Any host I/O write is taking place |
| ioDword | input | 1 | The current I/O write is 32 bits wide |
| ioOffset | input | 8 | Offset of the I/O write from the I/O base |
| burstPermit | input | 1 | Low forces the read-burst enable off |
| cfgRdData | output | 16 | Current word value |
| prioHigh | output | 1 | Arbitration priority bit |
| dwordMode | output | 1 | Sticky 32-bit I/O mode flag |
| rdBurstEn | output | 1 | Read-burst enable |
| wrBurstEn | output | 1 | Write-burst enable |

## Verification
Each stored bit goes straight to the read data and to its flag output with no extra register in between. A wrong internal state therefore shows at the ports one clock edge after the stimulus that caused it.

The main risk is a mode flag that is set by the wrong access, or cleared by anything other than a hard reset. The bench exercises both cases in the following ways:
- It sweeps every configuration write value.
- It sweeps every I/O offset at both access widths.
- It reads the word back after every step.

A burst enable that ignores the permit input shows up one edge after the permit input falls.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic cfgLoad;       // host configuration write
    logic dwordSet;      // qualifying 32-bit write to the data port seen
    logic rdBurstBlock;  // read bursting not permitted this cycle
  } bmcStrobe_t;
endpackage

// File: rtl/bmc_ctrl.sv
module bmc_ctrl
  import bmc_pkg::*;
#(
  parameter int OFS_W   = 8,
  parameter int RDP_OFS = 'h10
) (
  input  logic             cfgWrEn,
  input  logic             ioWrEn,
  input  logic             ioDword,
  input  logic [OFS_W-1:0] ioOffset,
  input  logic             burstPermit,
  output bmcStrobe_t       strobe
);
  localparam logic [OFS_W-1:0] RdpOfs = OFS_W'(RDP_OFS);

  logic hitRdp;

  always_comb begin
    hitRdp              = (ioOffset == RdpOfs);
    strobe.cfgLoad      = cfgWrEn;
    strobe.dwordSet     = ioWrEn && ioDword && hitRdp;
    strobe.rdBurstBlock = !burstPermit;
  end
endmodule

// File: rtl/bmc_dpath.sv
module bmc_dpath
  import bmc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PRIO_BIT = 9,
  parameter int RDB_BIT  = 6,
  parameter int WRB_BIT  = 5
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  bmcStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              prioHigh,
  output logic              dwordMode,
  output logic              rdBurstEn,
  output logic              wrBurstEn
);
  localparam logic [DATA_W-1:0] LoadMask =
    (DATA_W'(1) << PRIO_BIT) | (DATA_W'(1) << RDB_BIT) | (DATA_W'(1) << WRB_BIT);

  logic [DATA_W-1:0] wrMasked;
  logic prioNext, rdbNext, wrbNext, dwordNext;

  always_comb begin
    wrMasked  = wrData & LoadMask;
    prioNext  = strobe.cfgLoad ? wrMasked[PRIO_BIT] : prioHigh;
    wrbNext   = strobe.cfgLoad ? wrMasked[WRB_BIT]  : wrBurstEn;
    if (strobe.rdBurstBlock)  rdbNext = 1'b0;
    else if (strobe.cfgLoad)  rdbNext = wrMasked[RDB_BIT];
    else                      rdbNext = rdBurstEn;
    dwordNext = dwordMode || strobe.dwordSet;
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      prioHigh  <= 1'b0;
      dwordMode <= 1'b0;
      rdBurstEn <= 1'b0;
      wrBurstEn <= 1'b0;
    end else begin
      prioHigh  <= prioNext;
      dwordMode <= dwordNext;
      rdBurstEn <= rdbNext;
      wrBurstEn <= wrbNext;
    end
  end

  assert_dword_sticky_R7: assert property (@(posedge clk) disable iff (!hardRstN)
    dwordMode |=> dwordMode);

  assert_dword_cause_R5: assert property (@(posedge clk) disable iff (!hardRstN)
    $rose(dwordMode) |-> $past(strobe.dwordSet));

  assert_rdburst_block_R10: assert property (@(posedge clk) disable iff (!hardRstN)
    strobe.rdBurstBlock |=> !rdBurstEn);

  assert_softrst_hold_R8: assert property (@(posedge clk) disable iff (!hardRstN)
    (softRst && !strobe.cfgLoad && !strobe.dwordSet && !strobe.rdBurstBlock)
      |=> $stable({prioHigh, dwordMode, rdBurstEn, wrBurstEn}));
endmodule

// File: rtl/bus_mode_cfg_reg.sv
module bus_mode_cfg_reg
  import bmc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int OFS_W    = 8,
  parameter int RDP_OFS  = 'h10,
  parameter int PRIO_BIT = 9,
  parameter int RES_BIT  = 8,
  parameter int DWIO_BIT = 7,
  parameter int RDB_BIT  = 6,
  parameter int WRB_BIT  = 5
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              ioWrEn,
  input  logic              ioDword,
  input  logic [OFS_W-1:0]  ioOffset,
  input  logic              burstPermit,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              prioHigh,
  output logic              dwordMode,
  output logic              rdBurstEn,
  output logic              wrBurstEn
);
  localparam logic [DATA_W-1:0] LiveMask =
    (DATA_W'(1) << PRIO_BIT) | (DATA_W'(1) << RES_BIT) | (DATA_W'(1) << DWIO_BIT) |
    (DATA_W'(1) << RDB_BIT)  | (DATA_W'(1) << WRB_BIT);

  bmcStrobe_t strobe;

  bmc_ctrl #(.OFS_W(OFS_W), .RDP_OFS(RDP_OFS)) i_ctrl (
    .cfgWrEn    (cfgWrEn),
    .ioWrEn     (ioWrEn),
    .ioDword    (ioDword),
    .ioOffset   (ioOffset),
    .burstPermit(burstPermit),
    .strobe     (strobe)
  );

  bmc_dpath #(.DATA_W(DATA_W), .PRIO_BIT(PRIO_BIT), .RDB_BIT(RDB_BIT), .WRB_BIT(WRB_BIT)) i_dpath (
    .clk      (clk),
    .hardRstN (hardRstN),
    .softRst  (softRst),
    .strobe   (strobe),
    .wrData   (cfgWrData),
    .prioHigh (prioHigh),
    .dwordMode(dwordMode),
    .rdBurstEn(rdBurstEn),
    .wrBurstEn(wrBurstEn)
  );

  // read word assembly: one bit per position
  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == PRIO_BIT)      begin : g_prio assign cfgRdData[b] = prioHigh;  end
    else if (b == RES_BIT)  begin : g_res  assign cfgRdData[b] = 1'b1;      end
    else if (b == DWIO_BIT) begin : g_dw   assign cfgRdData[b] = dwordMode; end
    else if (b == RDB_BIT)  begin : g_rdb  assign cfgRdData[b] = rdBurstEn; end
    else if (b == WRB_BIT)  begin : g_wrb  assign cfgRdData[b] = wrBurstEn; end
    else                    begin : g_zero assign cfgRdData[b] = 1'b0;      end
  end

  assert_cfg_no_dword_R4: assert property (@(posedge clk) disable iff (!hardRstN)
    (cfgWrEn && !ioWrEn && !dwordMode) |=> !dwordMode);

  assert_narrow_no_dword_R6: assert property (@(posedge clk) disable iff (!hardRstN)
    (ioWrEn && !ioDword && !dwordMode) |=> !dwordMode);

  assert_permit_write_R9: assert property (@(posedge clk) disable iff (!hardRstN)
    (cfgWrEn && !burstPermit) |=> !rdBurstEn);

  assert_reserved_bits_R11: assert property (@(posedge clk) disable iff (!hardRstN)
    ((cfgRdData & ~LiveMask) == '0) && cfgRdData[RES_BIT]);
endmodule

// File: tb/test_bus_mode_cfg_reg.sv
module test_bus_mode_cfg_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        hardRstN = 1'b0;
  logic        softRst = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        ioWrEn = 1'b0;
  logic        ioDword = 1'b0;
  logic [7:0]  ioOffset = '0;
  logic        burstPermit = 1'b1;
  logic [15:0] cfgRdData;
  logic        prioHigh, dwordMode, rdBurstEn, wrBurstEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bus_mode_cfg_reg i_bus_mode_cfg_reg (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .ioWrEn(ioWrEn), .ioDword(ioDword), .ioOffset(ioOffset),
    .burstPermit(burstPermit), .cfgRdData(cfgRdData),
    .prioHigh(prioHigh), .dwordMode(dwordMode),
    .rdBurstEn(rdBurstEn), .wrBurstEn(wrBurstEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkFlags(input logic [15:0] word);
    check("R12 flags", {12'd0, prioHigh, dwordMode, rdBurstEn, wrBurstEn},
          {12'd0, word[9], word[7], word[6], word[5]});
  endtask

  // one configuration write; result sampled 1 time unit after the edge
  task automatic cfgWrite(input logic [15:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(posedge clk); #1; cfgWrEn = 1'b0;
  endtask

  task automatic ioWrite(input logic [7:0] ofs, input logic dw);
    @(negedge clk); ioWrEn = 1'b1; ioOffset = ofs; ioDword = dw;
    @(posedge clk); #1; ioWrEn = 1'b0; ioDword = 1'b0;
  endtask

  task automatic doHardReset();
    @(negedge clk); hardRstN = 1'b0;
    repeat (2) @(negedge clk);
    hardRstN = 1'b1;
  endtask

  initial begin
    logic [15:0] exp;
    repeat (3) @(negedge clk);
    check("R1 reset word", cfgRdData, 16'h0100);
    checkFlags(16'h0100);
    hardRstN = 1'b1;

    // R3 R2 R4 R11: every write value with permit high
    for (int w = 0; w < 65536; w++) begin
      cfgWrite(16'(w));
      exp = 16'h0100 | (16'(w) & 16'h0260);
      check("R3 R2 R4 R11 write sweep", cfgRdData, exp);
      checkFlags(exp);
    end

    // R6: all other offsets and widths must not set the mode flag
    cfgWrite(16'h0000);
    for (int o = 0; o < 256; o++) begin
      for (int d = 0; d < 2; d++) begin
        if (!(o == 'h10 && d == 1)) begin
          ioWrite(8'(o), 1'(d));
          check("R6 io sweep", cfgRdData, 16'h0100);
        end
      end
    end

    // R5: 32-bit write to 0x10 sets bit 7
    ioWrite(8'h10, 1'b1);
    check("R5 dword set", cfgRdData, 16'h0180);
    checkFlags(16'h0180);

    // R7 R4: config writes do not clear it
    cfgWrite(16'h0000);
    check("R7 R4 sticky after write", cfgRdData, 16'h0180);
    cfgWrite(16'h0260);
    check("R7 R3 sticky with fields", cfgRdData, 16'h03E0);

    // R8: soft reset changes nothing
    @(negedge clk); softRst = 1'b1;
    repeat (3) @(posedge clk);
    #1; softRst = 1'b0;
    check("R8 R7 soft reset hold", cfgRdData, 16'h03E0);

    // R10: permit drops, bit 6 clears at next edge only
    @(negedge clk); burstPermit = 1'b0; #1;
    check("R10 before edge", cfgRdData, 16'h03E0);
    @(posedge clk); #1;
    check("R10 after edge", cfgRdData, 16'h03A0);
    checkFlags(16'h03A0);

    // R9: writes to bit 6 blocked while permit low
    cfgWrite(16'h0040);
    check("R9 blocked rd burst", cfgRdData, 16'h0180);
    cfgWrite(16'hFFFF);
    check("R9 others load", cfgRdData, 16'h03A0);

    // permit back, writes reach bit 6 again
    @(negedge clk); burstPermit = 1'b1;
    cfgWrite(16'h0040);
    check("R3 permit restored", cfgRdData, 16'h01C0);

    // R7: only hard reset clears the mode flag
    doHardReset();
    #1;
    check("R7 R1 hard reset clears", cfgRdData, 16'h0100);
    checkFlags(16'h0100);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule